// File: doc/BRIEF.md
# MIDI channel message filter

This block sits behind a UART receiver and in front of a transmit FIFO in a MIDI processing path. It accepts one byte per handshake and follows running status. From the bytes that follow a status byte it assembles complete channel voice messages. Each complete message is looked up in a pass table. The table holds one bit for every combination of message type (0x8 to 0xE) and channel (1 to 16). A message whose bit is set is forwarded byte by byte on a ready/valid output. It always starts with an explicit status byte, so the output never relies on running status. A message whose bit is clear is dropped without a trace.

The filter is configured in-band by polyphonic key pressure messages on one fixed channel nibble (0xE by default, so status 0xAE). In such a message the key number picks the action and the pressure value is the argument. A configuration message is first judged against the table as it stands, and is forwarded if its own bit is set. Only then does it take effect. Every configuration write rebuilds the table one type row per cycle, and input is held off until the rebuild is done. Each forwarded message also raises a one-cycle strobe and presents its status byte for a display unit.

Top module: `midi_chan_filter`

## Requirements
- R1: Bytes 0xF8 to 0xFF are ignored entirely. They produce no output and leave the running status and any held first data byte unchanged.
- R2: Bytes 0xF0 to 0xF7 cancel the running status. Data bytes are then discarded until the next status byte in 0x80 to 0xEF, and a first data byte already held is lost.
- R3: A status byte in 0x80 to 0xEF sets the running status and restarts data counting. Later data bytes reuse it, and every forwarded message starts with its full status byte.
- R4: Types 0xC and 0xD complete after one data byte. Types 0x8, 0x9, 0xA, 0xB and 0xE complete after two data bytes, and the first is held until the second arrives.
- R5: A complete message is forwarded only if the table bit for its status byte is set: status, then the data bytes in order. Otherwise nothing is output.
- R6: After reset, in_ready is 1, out_valid and disp_stb are 0, and only status 0xBF passes.
- R7: A message 0xAE with key 21, 22, 23 or 24 loads value bits 3:0 into the enable bits of channels 1-4, 5-8, 9-12 or 13-16. Bit 0 is the lowest channel of the group.
- R8: A message 0xAE with key 25 loads value bits 6:0 as the type enables. Bit 6 is type 0x8, bit 5 is 0x9, and so on down to bit 0 for 0xE. A status passes exactly when its type and channel are both enabled.
- R9: A message 0xAE with key 26 restores the reset configuration: only channel 16 and only type 0xB are enabled. Other key numbers change nothing.
- R10: A configuration message is forwarded according to the table as it stood before that message took effect.
- R11: While out_ready is 0, out_valid and out_data hold. in_ready stays 0 while any message byte is pending, so no input byte is lost.
- R12: After the byte that completes a configuration message is taken, in_ready is 0 for exactly 8 cycles (one per type row) when the output is not stalled.
- R13: disp_stb pulses for one cycle per forwarded message, in the cycle its status byte first appears on out_data, and disp_status equals that status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Received MIDI byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Forwarded MIDI byte |
| out_ready | input | 1 | Downstream accepts out_data |
| disp_stb | output | 1 | One-cycle pulse per forwarded message |
| disp_status | output | 8 | Status byte of the last forwarded message |

## Verification
A configuration message whose own table bit is set completes in the same cycle that it loads the output serializer and starts the row rebuild. The bench provokes this by enabling type 0xA and channel 15, then sending further configuration messages. It expects each one to appear on the output, as judged by the old table. It also expects a full sweep of every status byte afterwards to follow only the new table. The second overlap is the row rebuild running beside a three-byte output. The bench measures that in_ready stays low for exactly the rebuild time, not the shorter drain time, and that no byte is lost or duplicated.

// File: rtl/midi_filt_pkg.sv
package midi_filt_pkg;

    localparam int NCHAN   = 16;
    localparam int NTYPE   = 7;
    localparam int NROWS   = 8;
    localparam int ROW_W   = $clog2(NROWS);
    localparam int GRP_W   = 4;
    localparam int MSG_MAX = 3;

    typedef logic [7:0] byte_t;

    localparam logic [NCHAN-1:0] DEF_CHAN  = 16'h8000;
    localparam logic [NTYPE-1:0] DEF_TYPES = 7'b0001000;

    localparam byte_t KEY_GRP_LO   = 8'd21;
    localparam byte_t KEY_GRP_HI   = 8'd24;
    localparam byte_t KEY_TYPES    = 8'd25;
    localparam byte_t KEY_DEFAULTS = 8'd26;

    typedef struct packed {
        byte_t status;
        byte_t d1;
        byte_t d2;
        logic  two_data;
    } msg_t;

    typedef enum logic [1:0] {
        CFG_NONE,
        CFG_CH_GRP,
        CFG_TYPES,
        CFG_DEFAULTS
    } cfg_op_e;

    typedef struct packed {
        cfg_op_e    op;
        logic [1:0] grp;
        logic [6:0] val;
    } cfg_t;

    function automatic logic is_realtime(byte_t b);
        return b >= 8'hF8;
    endfunction

    function automatic logic is_syscommon(byte_t b);
        return (b[7:4] == 4'hF) && !b[3];
    endfunction

    function automatic logic one_data(byte_t s);
        return (s[7:4] == 4'hC) || (s[7:4] == 4'hD);
    endfunction

    function automatic cfg_t decode_cfg(byte_t key, byte_t val);
        cfg_t  c;
        byte_t off;
        off   = key - KEY_GRP_LO;
        c.op  = CFG_NONE;
        c.grp = off[1:0];
        c.val = val[6:0];
        if (key >= KEY_GRP_LO && key <= KEY_GRP_HI)
            c.op = CFG_CH_GRP;
        else if (key == KEY_TYPES)
            c.op = CFG_TYPES;
        else if (key == KEY_DEFAULTS)
            c.op = CFG_DEFAULTS;
        return c;
    endfunction

    function automatic logic [NCHAN-1:0] row_fill(int r, logic [NCHAN-1:0] chans,
                                                   logic [NTYPE-1:0] types);
        logic [NCHAN-1:0] res;
        res = '0;
        if (r < NTYPE) begin
            if (types[NTYPE-1-r])
                res = chans;
        end
        return res;
    endfunction

endpackage

// File: rtl/midi_msg_parser.sv
module midi_msg_parser
    import midi_filt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  byte_t rx_byte,
    output logic  done,
    output msg_t  msg
);

    byte_t rs_q;
    logic  rs_valid_q;
    logic  have_d1_q;
    byte_t d1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q       <= '0;
            rs_valid_q <= 1'b0;
            have_d1_q  <= 1'b0;
            d1_q       <= '0;
        end else if (take) begin
            if (is_realtime(rx_byte)) begin
                rs_valid_q <= rs_valid_q;
            end else if (is_syscommon(rx_byte)) begin
                rs_valid_q <= 1'b0;
                have_d1_q  <= 1'b0;
            end else if (rx_byte[7]) begin
                rs_q       <= rx_byte;
                rs_valid_q <= 1'b1;
                have_d1_q  <= 1'b0;
            end else if (rs_valid_q) begin
                if (one_data(rs_q)) begin
                    have_d1_q <= 1'b0;
                end else if (!have_d1_q) begin
                    d1_q      <= rx_byte;
                    have_d1_q <= 1'b1;
                end else begin
                    have_d1_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        done         = take && !rx_byte[7] && rs_valid_q && (one_data(rs_q) || have_d1_q);
        msg.status   = rs_q;
        msg.d1       = one_data(rs_q) ? rx_byte : d1_q;
        msg.d2       = rx_byte;
        msg.two_data = !one_data(rs_q);
    end

endmodule

// File: rtl/midi_pass_table.sv
module midi_pass_table
    import midi_filt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_valid,
    input  cfg_t       cfg,
    input  logic [6:0] look_idx,
    output logic       pass,
    output logic       busy
);

    logic [NCHAN-1:0] chan_q;
    logic [NTYPE-1:0] type_q;
    logic [NCHAN-1:0] row_q [NROWS];
    logic             busy_q;
    logic [ROW_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= DEF_CHAN;
            type_q <= DEF_TYPES;
            busy_q <= 1'b0;
            ptr_q  <= '0;
            for (int r = 0; r < NROWS; r++)
                row_q[r] <= row_fill(r, DEF_CHAN, DEF_TYPES);
        end else if (cfg_valid && cfg.op != CFG_NONE) begin
            case (cfg.op)
                CFG_CH_GRP:   chan_q[cfg.grp*GRP_W +: GRP_W] <= cfg.val[GRP_W-1:0];
                CFG_TYPES:    type_q <= cfg.val;
                CFG_DEFAULTS: begin
                    chan_q <= DEF_CHAN;
                    type_q <= DEF_TYPES;
                end
                default:      type_q <= type_q;
            endcase
            busy_q <= 1'b1;
            ptr_q  <= '0;
        end else if (busy_q) begin
            row_q[ptr_q] <= row_fill(int'(ptr_q), chan_q, type_q);
            if (ptr_q == ROW_W'(NROWS-1))
                busy_q <= 1'b0;
            else
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign pass = row_q[look_idx[6:4]][look_idx[3:0]];
    assign busy = busy_q;

endmodule

// File: rtl/midi_msg_serializer.sv
module midi_msg_serializer
    import midi_filt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  msg_t  msg,
    input  logic  out_ready,
    output logic  out_valid,
    output byte_t out_data,
    output logic  busy,
    output logic  stb,
    output byte_t stb_status
);

    localparam int IDX_W = $clog2(MSG_MAX);

    logic [MSG_MAX-1:0][7:0] bytes_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        last_q;
    logic                    valid_q;
    logic                    stb_q;
    byte_t                   stb_status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q      <= '0;
            idx_q        <= '0;
            last_q       <= '0;
            valid_q      <= 1'b0;
            stb_q        <= 1'b0;
            stb_status_q <= '0;
        end else begin
            stb_q <= 1'b0;
            if (load) begin
                bytes_q[0]   <= msg.status;
                bytes_q[1]   <= msg.d1;
                bytes_q[2]   <= msg.d2;
                idx_q        <= '0;
                last_q       <= msg.two_data ? IDX_W'(2) : IDX_W'(1);
                valid_q      <= 1'b1;
                stb_q        <= 1'b1;
                stb_status_q <= msg.status;
            end else if (valid_q && out_ready) begin
                if (idx_q == last_q)
                    valid_q <= 1'b0;
                else
                    idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_data   = bytes_q[idx_q];
    assign busy       = valid_q;
    assign stb        = stb_q;
    assign stb_status = stb_status_q;

endmodule

// File: rtl/midi_chan_filter.sv
module midi_chan_filter
    import midi_filt_pkg::*;
#(
    parameter logic [3:0] CFG_CHANNEL = 4'hE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    output logic       disp_stb,
    output logic [7:0] disp_status
);

    localparam byte_t CFG_STATUS = {4'hA, CFG_CHANNEL};

    logic take;
    logic msg_done;
    msg_t msg;
    logic pass;
    logic tbl_busy;
    logic ser_busy;
    logic cfg_hit;
    cfg_t cfg;

    assign in_ready = !ser_busy && !tbl_busy;
    assign take     = in_valid && in_ready;
    assign cfg_hit  = msg_done && (msg.status == CFG_STATUS);
    assign cfg      = decode_cfg(msg.d1, msg.d2);

    midi_msg_parser u_parser (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .rx_byte (in_data),
        .done    (msg_done),
        .msg     (msg)
    );

    midi_pass_table u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_hit),
        .cfg       (cfg),
        .look_idx  (msg.status[6:0]),
        .pass      (pass),
        .busy      (tbl_busy)
    );

    midi_msg_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .load       (msg_done && pass),
        .msg        (msg),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .busy       (ser_busy),
        .stb        (disp_stb),
        .stb_status (disp_status)
    );

endmodule

// File: rtl/midi_chan_filter_chk.sv
module midi_chan_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       disp_stb,
    input logic [7:0] disp_status
);

    p_rt_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_data >= 8'hF8) |=> !out_valid);

    p_lead_status_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_data[7]);

    p_hold_out_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_take_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_strobe_r13: assert property (@(posedge clk) disable iff (rst)
        disp_stb |-> (out_valid && out_data == disp_status));

    p_strobe_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        disp_stb |=> !disp_stb);

endmodule

bind midi_chan_filter midi_chan_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .disp_stb    (disp_stb),
    .disp_status (disp_status)
);

// File: tb/sim_midi_chan_filter.sv
`timescale 1ns/1ps
module sim_midi_chan_filter;

    localparam int REBUILD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;
    logic       disp_stb;
    logic [7:0] disp_status;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    int stb_cnt = 0;
    int exp_msgs = 0;

    logic [15:0] m_chan;
    logic [6:0]  m_types;

    always #2 clk = ~clk;

    midi_chan_filter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .disp_stb(disp_stb), .disp_status(disp_status)
    );

    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (disp_stb) stb_cnt++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic m_pass(logic [7:0] s);
        return m_types[6 - int'(s[6:4])] && m_chan[s[3:0]];
    endfunction

    function automatic logic m_one(logic [7:0] s);
        return s[7:4] == 4'hC || s[7:4] == 4'hD;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_msg(input logic [7:0] s, input logic [7:0] a, input logic [7:0] b);
        exp_q.push_back(s);
        exp_q.push_back(a);
        if (!m_one(s)) exp_q.push_back(b);
        exp_msgs++;
    endtask

    task automatic send_msg(input logic [7:0] s, input logic [7:0] a, input logic [7:0] b);
        send(s);
        send(a);
        if (!m_one(s)) send(b);
        if (m_pass(s)) expect_msg(s, a, b);
    endtask

    task automatic drain(input string tag);
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (in_ready && !out_valid) quiet++;
            else quiet = 0;
        end
        check({tag, " byte count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got_q.size()) check(tag, got_q[i], exp_q[i]);
        end
        check({tag, " strobes R13"}, stb_cnt, exp_msgs);
        got_q.delete();
        exp_q.delete();
        stb_cnt = 0;
        exp_msgs = 0;
    endtask

    // configuration message: judged on old table (R10), then applied (R7 R8 R9), R12 hold-off
    task automatic send_cfg(input logic [7:0] key, input logic [7:0] val);
        int low = 0;
        send(8'hAE);
        send(key);
        if (m_pass(8'hAE)) expect_msg(8'hAE, key, val);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = val;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) begin
            low++;
            @(negedge clk);
        end
        if (key >= 21 && key <= 26) check("R12 rebuild hold-off", low, REBUILD);
        if (key >= 21 && key <= 24) m_chan[(int'(key) - 21)*4 +: 4] = val[3:0];
        else if (key == 25) m_types = val[6:0];
        else if (key == 26) begin m_chan = 16'h8000; m_types = 7'b0001000; end
    endtask

    task automatic sweep(input string tag);
        for (int s = 8'h80; s <= 8'hEF; s++) begin
            send_msg(8'(s), 8'(s) & 8'h7F, ~8'(s) & 8'h7F);
            drain(tag);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_chan  = 16'h8000;
        m_types = 7'b0001000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R6 in_ready after reset", in_ready, 1);
        check("R6 out_valid after reset", out_valid, 0);
        check("R6 disp_stb after reset", disp_stb, 0);

        sweep("R6 R5 default table");

        // R3 running status, explicit status on output
        send(8'hBF); send(8'h10); send(8'h20); send(8'h30); send(8'h40);
        expect_msg(8'hBF, 8'h10, 8'h20); expect_msg(8'hBF, 8'h30, 8'h40);
        drain("R3 running status");

        // R1 real-time bytes inside a message
        send(8'hBF); send(8'h11); send(8'hF8); send(8'h22); send(8'hFE);
        send(8'h33); send(8'hFF); send(8'h44);
        expect_msg(8'hBF, 8'h11, 8'h22); expect_msg(8'hBF, 8'h33, 8'h44);
        drain("R1 real-time ignored");

        // R2 system common cancels running status
        send(8'hBF); send(8'h10); send(8'hF0); send(8'h20); send(8'h30);
        send(8'hBF); send(8'h01); send(8'h02);
        send(8'hF7); send(8'h05); send(8'h06);
        expect_msg(8'hBF, 8'h01, 8'h02);
        drain("R2 system common");

        // R4 one-data types with running status
        send_cfg(8'd25, 8'h0E);
        send(8'hCF); send(8'h05); send(8'h06);
        expect_msg(8'hCF, 8'h05, 8'h00); expect_msg(8'hCF, 8'h06, 8'h00);
        send(8'hDF); send(8'h11);
        expect_msg(8'hDF, 8'h11, 8'h00);
        send_msg(8'hEF, 8'h01, 8'h02);
        drain("R4 data byte count");

        // R9 defaults, unknown key ignored
        send_cfg(8'd30, 8'h7F);
        send_cfg(8'd26, 8'h00);
        sweep("R9 restored defaults");

        // R7 R8 mixed configuration
        send_cfg(8'd21, 8'h05);
        send_cfg(8'd22, 8'h0A);
        send_cfg(8'd23, 8'h03);
        send_cfg(8'd24, 8'h0C);
        send_cfg(8'd25, 8'h55);
        drain("R7 R8 config messages");
        sweep("R7 R8 cross table");

        // R10 config message itself passes on old table
        send_cfg(8'd25, 8'h40);
        drain("R10 passed config");
        sweep("R10 only type 8");
        send_cfg(8'd25, 8'h10);
        drain("R10 dropped config");
        sweep("R10 only type A");

        // R11 explicit stall
        send_cfg(8'd21, 8'h0F); send_cfg(8'd22, 8'h0F);
        send_cfg(8'd23, 8'h0F); send_cfg(8'd24, 8'h0F);
        send_cfg(8'd25, 8'h7F);
        drain("R7 all enabled");
        rdy_mode = 2;
        send(8'h93); send(8'h21); send(8'h22);
        expect_msg(8'h93, 8'h21, 8'h22);
        repeat (10) @(negedge clk);
        check("R11 out_valid held", out_valid, 1);
        check("R11 out_data held", out_data, 8'h93);
        check("R11 in_ready low", in_ready, 0);
        @(posedge clk); #1 rdy_mode = 0;
        drain("R11 after release");

        // R11 random backpressure across all statuses
        @(posedge clk); #1 rdy_mode = 1;
        sweep("R11 random stall");
        @(posedge clk); #1 rdy_mode = 0;

        send_cfg(8'd26, 8'h00);
        drain("R9 defaults config");
        sweep("R9 defaults again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule